// File: doc/BRIEF.md
# Toggle-Clear Interrupt Status Controller

This block gathers the interrupt sources of a serial peripheral controller into one sticky status word and turns that word into a single level-sensitive interrupt line. Single-cycle event pulses come from the transfer engine: a byte was exchanged, the transmit side ran dry, the receive side dropped a byte, or the transmit queue fell to half. Two level inputs report the receive FIFO state: it holds data, or it is full. Each source owns one status bit. That bit stays set until software changes it.

Software reaches three word registers over a simple write-strobe bus with a combinational read port. The status word sits at offset 0x20, the per-bit enable word at 0x28 and the master gate at 0x1C. A write to the status word inverts every bit written as 1, so software clears a bit by writing 1 to it while that bit is set. A level source keeps setting its bit for as long as its condition holds. The interrupt line is registered. It is high when the master gate is on and at least one set status bit is also enabled.

Top module: `spi_irq_status`

## Requirements
- R1: While `rst_n` is low, and after it is released, the status, enable and gate registers read 0 and `irq_o` is 0.
- R2: Address decode. Offset 0x1C is the gate register, with only bit 31 stored. Offset 0x20 is the status register. Offset 0x28 is the enable register. Reads from any other offset return 0, and writes to any other offset change no register.
- R3: A write to offset 0x20 inverts each status bit whose written value is 1 and leaves the other status bits unchanged.
- R4: Status bit positions are: 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty, 8 receive not empty. Pulses set bits as follows. `ev_xfer` sets bits 2 and 8. `ev_tx_underrun` sets bit 3. `ev_rx_overrun` sets bit 5. `ev_tx_half` sets bit 6. The new value is visible on the clock edge after the pulse.
- R5: While `lv_rx_nonempty` or `lv_rx_full` is high, status bit 8 or bit 4 respectively is set again on every clock edge. A toggle that clears such a bit while its condition holds leaves the bit at 1.
- R6: An event or level that arrives in the same cycle as a status write is applied after the inversion, so the bit it sets reads 1.
- R7: `irq_o` equals the value of (gate bit 31 AND any bit of status AND enable) sampled at the previous clock edge. It therefore changes one edge after a register changes.
- R8: A one-cycle `soft_rst` pulse clears the status, enable and gate registers on the next edge. It takes precedence over bus writes and events in that cycle.
- R9: Only bits 2, 3, 4, 5, 6 and 8 of status and enable, and only bit 31 of gate, can hold a 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per word write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| soft_rst | input | 1 | Software reset pulse for all three registers |
| ev_xfer | input | 1 | Byte-exchanged pulse |
| ev_tx_underrun | input | 1 | Transmit underrun pulse |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_tx_half | input | 1 | Transmit half-empty pulse |
| lv_rx_nonempty | input | 1 | Receive FIFO holds data (level) |
| lv_rx_full | input | 1 | Receive FIFO full (level) |
| irq_o | output | 1 | Registered interrupt level |

## Verification
Register contents change on the edge that samples a write, event, level or soft reset. Because the read port is combinational, the bench reads the result half a cycle after that edge. The interrupt line has one more register stage, so it is checked on two edges after each cause. On the first edge it must still show the old value, and on the second edge it shows the new one. All stimulus is applied on the falling clock edge, and every sample is taken on a falling edge after the rising edge it depends on.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned BIT_TX_EMPTY   = 2;
  localparam int unsigned BIT_TX_UNDER   = 3;
  localparam int unsigned BIT_RX_FULL    = 4;
  localparam int unsigned BIT_RX_OVER    = 5;
  localparam int unsigned BIT_TX_HALF    = 6;
  localparam int unsigned BIT_RX_NONEMPT = 8;
  localparam int unsigned BIT_GATE       = 31;

  localparam logic [REG_W-1:0] FLAG_VALID =
    (REG_W'(1) << BIT_TX_EMPTY) | (REG_W'(1) << BIT_TX_UNDER) |
    (REG_W'(1) << BIT_RX_FULL)  | (REG_W'(1) << BIT_RX_OVER)  |
    (REG_W'(1) << BIT_TX_HALF)  | (REG_W'(1) << BIT_RX_NONEMPT);

  localparam logic [REG_W-1:0] GATE_VALID = REG_W'(1) << BIT_GATE;

  typedef struct packed {
    logic gate;
    logic flags;
    logic mask;
  } reg_sel_t;
endpackage

// File: rtl/isc_decode.sv
module isc_decode
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFF_GATE = 'h1C,
  parameter int unsigned OFF_FLAG = 'h20,
  parameter int unsigned OFF_MASK = 'h28
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  gate_q,
  input  logic [REG_W-1:0]  flags_q,
  input  logic [REG_W-1:0]  mask_q,
  output reg_sel_t          wr_sel,
  output logic [REG_W-1:0]  rdata
);
  reg_sel_t hit;

  always_comb begin
    hit.gate  = (addr == ADDR_W'(OFF_GATE));
    hit.flags = (addr == ADDR_W'(OFF_FLAG));
    hit.mask  = (addr == ADDR_W'(OFF_MASK));
  end

  always_comb begin
    wr_sel.gate  = wr & hit.gate;
    wr_sel.flags = wr & hit.flags;
    wr_sel.mask  = wr & hit.mask;
  end

  always_comb begin
    rdata = '0;
    if (hit.gate)  rdata = gate_q;
    if (hit.flags) rdata = flags_q;
    if (hit.mask)  rdata = mask_q;
  end
endmodule

// File: rtl/isc_flags.sv
module isc_flags
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tog_we,
  input  logic [REG_W-1:0] tog_val,
  input  logic [REG_W-1:0] evt_in,
  input  logic [REG_W-1:0] lvl_in,
  output logic [REG_W-1:0] flags_q
);
  logic [REG_W-1:0] set_in;

  always_comb set_in = evt_in | lvl_in;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (FLAG_VALID[b]) begin : g_live
      logic d_bit;
      logic q_bit;
      logic en_bit;

      always_comb begin
        en_bit = soft_rst | tog_we | set_in[b];
        if (soft_rst) d_bit = 1'b0;
        else          d_bit = (q_bit ^ (tog_we & tog_val[b])) | set_in[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_bit <= 1'b0;
        else if (en_bit) q_bit <= d_bit;
      end

      assign flags_q[b] = q_bit;
    end else begin : g_dead
      assign flags_q[b] = 1'b0;
    end
  end

  p_level_reassert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_in[BIT_RX_NONEMPT] && !soft_rst) |=> flags_q[BIT_RX_NONEMPT]);

  p_full_reassert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_in[BIT_RX_FULL] && !soft_rst) |=> flags_q[BIT_RX_FULL]);

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in[BIT_TX_UNDER] && tog_we && !soft_rst) |=> flags_q[BIT_TX_UNDER]);

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_we && !soft_rst && set_in == '0) |=>
      flags_q == ($past(flags_q) ^ ($past(tog_val) & FLAG_VALID)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_we && !soft_rst && set_in == '0) |=> $stable(flags_q));

  p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> flags_q == '0);
endmodule

// File: rtl/isc_ctl_regs.sv
module isc_ctl_regs
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             gate_we,
  input  logic             mask_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] gate_q,
  output logic [REG_W-1:0] mask_q
);
  logic [REG_W-1:0] gate_d, mask_d;
  logic             gate_en, mask_en;

  always_comb begin
    gate_en = soft_rst | gate_we;
    mask_en = soft_rst | mask_we;
    gate_d  = soft_rst ? '0 : (wdata & GATE_VALID);
    mask_d  = soft_rst ? '0 : (wdata & FLAG_VALID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= '0;
    else if (gate_en) gate_q <= gate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  p_ctl_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (gate_q == '0 && mask_q == '0));

  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !gate_we && !mask_we) |=> ($stable(gate_q) && $stable(mask_q)));
endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] gate_q,
  input  logic [REG_W-1:0] flags_q,
  input  logic [REG_W-1:0] mask_q,
  output logic             irq_o
);
  logic irq_d;

  always_comb irq_d = gate_q[BIT_GATE] & (|(flags_q & mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end

  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q[BIT_GATE] |=> !irq_o);

  p_no_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & mask_q) == '0) |=> !irq_o);

  p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q[BIT_GATE] && (flags_q & mask_q) != '0) |=> irq_o);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFF_GATE = 'h1C,
  parameter int unsigned OFF_FLAG = 'h20,
  parameter int unsigned OFF_MASK = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              soft_rst,
  input  logic              ev_xfer,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half,
  input  logic              lv_rx_nonempty,
  input  logic              lv_rx_full,
  output logic              irq_o
);
  reg_sel_t         wr_sel;
  logic [REG_W-1:0] gate_q, flags_q, mask_q;
  logic [REG_W-1:0] evt_vec, lvl_vec;

  always_comb begin
    evt_vec = '0;
    evt_vec[BIT_TX_EMPTY]   = ev_xfer;
    evt_vec[BIT_RX_NONEMPT] = ev_xfer;
    evt_vec[BIT_TX_UNDER]   = ev_tx_underrun;
    evt_vec[BIT_RX_OVER]    = ev_rx_overrun;
    evt_vec[BIT_TX_HALF]    = ev_tx_half;
    lvl_vec = '0;
    lvl_vec[BIT_RX_NONEMPT] = lv_rx_nonempty;
    lvl_vec[BIT_RX_FULL]    = lv_rx_full;
  end

  isc_decode #(
    .ADDR_W(ADDR_W), .OFF_GATE(OFF_GATE), .OFF_FLAG(OFF_FLAG), .OFF_MASK(OFF_MASK)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr), .gate_q(gate_q), .flags_q(flags_q),
    .mask_q(mask_q), .wr_sel(wr_sel), .rdata(bus_rdata)
  );

  isc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tog_we(wr_sel.flags),
    .tog_val(bus_wdata), .evt_in(evt_vec), .lvl_in(lvl_vec), .flags_q(flags_q)
  );

  isc_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .gate_we(wr_sel.gate),
    .mask_we(wr_sel.mask), .wdata(bus_wdata), .gate_q(gate_q), .mask_q(mask_q)
  );

  isc_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .flags_q(flags_q),
    .mask_q(mask_q), .irq_o(irq_o)
  );

  p_xfer_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer && !soft_rst) |=> (bus_addr != ADDR_W'(OFF_FLAG)) ||
      (bus_rdata[BIT_TX_EMPTY] && bus_rdata[BIT_RX_NONEMPT]));

  p_unused_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_MASK)) |-> (bus_rdata & ~FLAG_VALID) == '0);
endmodule

// File: tb/spi_irq_status_tb.sv
`timescale 1ns/1ps
module spi_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        soft_rst, ev_xfer, ev_tx_underrun, ev_rx_overrun, ev_tx_half;
  logic        lv_rx_nonempty, lv_rx_full;
  logic        irq_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  spi_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .soft_rst(soft_rst),
    .ev_xfer(ev_xfer), .ev_tx_underrun(ev_tx_underrun), .ev_rx_overrun(ev_rx_overrun),
    .ev_tx_half(ev_tx_half), .lv_rx_nonempty(lv_rx_nonempty), .lv_rx_full(lv_rx_full),
    .irq_o(irq_o)
  );

  localparam logic [7:0] A_GATE = 8'h1C;
  localparam logic [7:0] A_FLAG = 8'h20;
  localparam logic [7:0] A_MASK = 8'h28;

  // {wr, wdata, ev{xfer,under,over,half}, lv{nonempty,full}, expected status}
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 4'b1000, 2'b00, 32'h0000_0104},
    {1'b1, 32'h0000_0004, 4'b0000, 2'b00, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 4'b0000, 2'b00, 32'h0000_0000},
    {1'b1, 32'hFFFF_FFFF, 4'b0000, 2'b00, 32'h0000_017C},
    {1'b1, 32'h0000_017C, 4'b0100, 2'b00, 32'h0000_0008},
    {1'b0, 32'h0000_0000, 4'b0011, 2'b00, 32'h0000_0068},
    {1'b1, 32'h0000_0008, 4'b0000, 2'b10, 32'h0000_0160},
    {1'b1, 32'h0000_0100, 4'b0000, 2'b10, 32'h0000_0160},
    {1'b1, 32'h0000_0060, 4'b0000, 2'b01, 32'h0000_0110},
    {1'b1, 32'h0000_0110, 4'b0000, 2'b00, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_wdata = '0; soft_rst = 0;
    ev_xfer = 0; ev_tx_underrun = 0; ev_rx_overrun = 0; ev_tx_half = 0;
    lv_rx_nonempty = 0; lv_rx_full = 0;
  endtask

  // Drive at falling edge, commit at next rising edge, return at following falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 0; bus_addr = '0; idle();
    repeat (3) @(negedge clk);
    // R1: during reset
    rd_check("R1 gate in reset", A_GATE, 32'h0);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd_check("R1 status after reset", A_FLAG, 32'h0);
    rd_check("R1 enable after reset", A_MASK, 32'h0);
    rd_check("R1 gate after reset", A_GATE, 32'h0);

    // Vector walk: R3 toggles, R4 events, R5 levels, R6 same-cycle ordering
    for (int i = 0; i < NV; i++) begin
      bus_addr = A_FLAG;
      bus_wr = VEC[i][70];
      bus_wdata = VEC[i][69:38];
      ev_xfer = VEC[i][37]; ev_tx_underrun = VEC[i][36];
      ev_rx_overrun = VEC[i][35]; ev_tx_half = VEC[i][34];
      lv_rx_nonempty = VEC[i][33]; lv_rx_full = VEC[i][32];
      @(negedge clk);
      idle();
      rd_check($sformatf("R3/R4/R5/R6 vector %0d", i), A_FLAG, VEC[i][31:0]);
    end

    // R2 / R9: masking of unused bits, decode of stray offsets
    wr_reg(A_GATE, 32'hFFFF_FFFF);
    rd_check("R2 R9 gate keeps bit 31 only", A_GATE, 32'h8000_0000);
    wr_reg(A_MASK, 32'hFFFF_FFFF);
    rd_check("R9 enable unused bits zero", A_MASK, 32'h0000_017C);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_check("R2 stray offset reads zero", 8'h24, 32'h0);
    rd_check("R2 stray write leaves status", A_FLAG, 32'h0);
    rd_check("R2 stray write leaves enable", A_MASK, 32'h0000_017C);
    check("R7 no source no irq", {31'b0, irq_o}, 32'h0);

    // R7: latency of irq rise
    ev_tx_underrun = 1;
    @(negedge clk);
    idle();
    check("R7 irq not yet high", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7 irq high one edge later", {31'b0, irq_o}, 32'h1);
    // R7: gate off drops irq one edge later
    wr_reg(A_GATE, 32'h0);
    check("R7 irq still high after gate write", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R7 irq low after gate off", {31'b0, irq_o}, 32'h0);
    // R7: enable without the source bit
    wr_reg(A_GATE, 32'h8000_0000);
    wr_reg(A_MASK, 32'h0000_0100);
    @(negedge clk);
    check("R7 masked source no irq", {31'b0, irq_o}, 32'h0);
    wr_reg(A_MASK, 32'h0000_0008);
    @(negedge clk);
    check("R7 enabled source irq", {31'b0, irq_o}, 32'h1);

    // R8: soft reset with competing write and event in same cycle
    soft_rst = 1; ev_rx_overrun = 1; bus_addr = A_FLAG; bus_wr = 1; bus_wdata = 32'h0000_0004;
    @(negedge clk);
    idle();
    rd_check("R8 status cleared", A_FLAG, 32'h0);
    rd_check("R8 enable cleared", A_MASK, 32'h0);
    rd_check("R8 gate cleared", A_GATE, 32'h0);
    @(negedge clk);
    check("R8 R7 irq low after soft reset", {31'b0, irq_o}, 32'h0);

    // R5: level still held after soft reset re-sets its bit
    lv_rx_nonempty = 1; soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    rd_check("R5 R8 cleared under held level", A_FLAG, 32'h0);
    @(negedge clk);
    idle();
    rd_check("R5 level re-sets bit 8", A_FLAG, 32'h0000_0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule